// File: doc/BRIEF.md
# Bus-Master DMA Status Register and Transfer Watchdog

This block holds the eight-bit status byte of one bus-master disk DMA channel and the watchdog that judges a transfer that runs past its time limit. The DMA engine reports its running state and pulses error and interrupt events into the byte. Host software reads the byte, clears latched events by writing ones, and sets or clears the two per-drive DMA-capable flags. A dedicated command clears the flag of a single drive and leaves every other bit alone.

The watchdog is armed when a transfer starts and counts a shared timer tick up to a programmable limit. On expiry it inspects the status byte and issues a two-bit verdict: keep waiting, fail the transfer, reset the bus, or fall back to programmed I/O. A transfer gets one grace extension only. An expiry seen while the engine reports a too-early timer condition (bits 3 and 4 both set) asks for another wait without spending that grace. When the transfer ends, the block reports whether it completed cleanly from the error bit and the drive's ready and data-request lines.

Top module: `bmdma_status_wdog`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00, and `verdict_valid` and `done_valid` are 0.
- R2: Status bit 0 shows `eng_active` one cycle later. Bits 3 and 4 show `eng_aux[0]` and `eng_aux[1]` one cycle later. Bit 7 reads 0. Host writes have no effect on bits 0, 3, 4 and 7.
- R3: Bit 1 (error) and bit 2 (interrupt) are set by a pulse on `eng_err_evt` and `eng_irq_evt`. A host write with a 1 in that bit position clears the bit and a 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R4: Bits 5 and 6 (DMA-capable flags of drive 0 and drive 1) take the written value on a host write.
- R5: A pulse on `unit_off_req` clears only bit 5+`unit_off_sel` and leaves all other bits unchanged. It takes precedence over a same-cycle host write to that bit.
- R6: A pulse on `xfer_start` arms the watchdog with a fresh count and an unspent grace. While armed, the watchdog expires on the `cfg_timeout`-th tick, where 0 acts as 1. `verdict_valid` pulses for one cycle in the cycle after the expiring tick. Ticks while unarmed produce nothing.
- R7: If status bits 3 and 4 are both set at expiry and the grace is unspent, the verdict is wait (2'b00) and the grace stays unspent.
- R8: In any other expiry with the grace unspent, the grace becomes spent. The verdict is then fail (2'b01) if bit 1 is set, otherwise wait (2'b00) if bit 0 or bit 2 is set, otherwise bus reset (2'b10).
- R9: An expiry with the grace already spent gives programmed-I/O fallback (2'b11). After any verdict other than wait the watchdog is disarmed.
- R10: After a wait verdict the watchdog stays armed and counts a full `cfg_timeout` ticks again from zero.
- R11: A pulse on `xfer_end` disarms the watchdog. In the next cycle `done_valid` is 1 and `done_ok` = (bit 1 clear) AND `drv_ready` AND NOT `drv_drq`. An expiry in the same cycle as `xfer_end` gives no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_active | input | 1 | Engine is moving data |
| eng_err_evt | input | 1 | Engine error event pulse |
| eng_irq_evt | input | 1 | Engine interrupt event pulse |
| eng_aux | input | 2 | Engine early-timer indications, shown in bits 3 and 4 |
| reg_wr | input | 1 | Host write strobe for the status byte |
| reg_wdata | input | 8 | Host write data |
| unit_off_req | input | 1 | Clear one drive's DMA-capable flag |
| unit_off_sel | input | 1 | Drive selected by `unit_off_req` |
| status | output | 8 | Registered status byte |
| tick | input | 1 | Watchdog timer tick |
| cfg_timeout | input | TW | Ticks until expiry |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_end | input | 1 | Transfer end pulse |
| drv_ready | input | 1 | Drive reports ready |
| drv_drq | input | 1 | Drive still requests data |
| verdict_valid | output | 1 | Watchdog verdict pulse |
| verdict | output | 2 | 00 wait, 01 fail, 10 bus reset, 11 PIO fallback |
| done_valid | output | 1 | Completion report pulse |
| done_ok | output | 1 | Transfer completed cleanly |

## Verification
The hardest situation to reach is an expiry that must tell an unspent grace from a spent one. The early-timer wait leaves the grace untouched, so a later expiry with no status bits gives bus reset and not fallback. An active-bit wait spends the grace, so the very next expiry falls back. The bench builds both histories on one armed transfer by changing `eng_aux`, `eng_active` and the latched error bit between tick bursts. It queues the verdict each expiry should produce, and these are checked against the verdicts the design issues.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int ST_W = 8;
  localparam int B_ACT = 0;
  localparam int B_ERR = 1;
  localparam int B_IRQ = 2;
  localparam int B_AUXL = 3;
  localparam int B_AUXH = 4;
  localparam int B_CAP0 = 5;
  localparam int B_CAP1 = 6;

  typedef enum logic [1:0] {
    V_WAIT   = 2'd0,
    V_FAIL   = 2'd1,
    V_BUSRST = 2'd2,
    V_PIO    = 2'd3
  } verdict_e;
endpackage

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
  import bmdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            eng_active,
  input  logic            eng_err_evt,
  input  logic            eng_irq_evt,
  input  logic [1:0]      eng_aux,
  input  logic            reg_wr,
  input  logic [ST_W-1:0] reg_wdata,
  input  logic            unit_off_req,
  input  logic            unit_off_sel,
  output logic [ST_W-1:0] st_q
);
  logic [ST_W-1:0] st_d;
  logic [1:0]      cap_d;

  always_comb begin
    st_d = '0;
    st_d[B_ACT]  = eng_active;
    st_d[B_AUXL] = eng_aux[0];
    st_d[B_AUXH] = eng_aux[1];
    st_d[B_ERR]  = eng_err_evt | (st_q[B_ERR] & ~(reg_wr & reg_wdata[B_ERR]));
    st_d[B_IRQ]  = eng_irq_evt | (st_q[B_IRQ] & ~(reg_wr & reg_wdata[B_IRQ]));
    cap_d = reg_wr ? reg_wdata[B_CAP1:B_CAP0] : st_q[B_CAP1:B_CAP0];
    if (unit_off_req) cap_d[unit_off_sel] = 1'b0;
    st_d[B_CAP1:B_CAP0] = cap_d;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  // R2
  act_follow_chk: assert property (@(posedge clk) disable iff (rst)
    eng_active |=> st_q[B_ACT]);
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    eng_err_evt |=> st_q[B_ERR]);
  // R5
  unit0_off_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_off_req && !unit_off_sel && !reg_wr) |=> (!st_q[B_CAP0] && st_q[B_CAP1] == $past(st_q[B_CAP1])));
endmodule

// File: rtl/bmdma_watchdog.sv
module bmdma_watchdog
  import bmdma_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [TW-1:0]   cfg_timeout,
  input  logic            xfer_start,
  input  logic            xfer_end,
  input  logic            drv_ready,
  input  logic            drv_drq,
  input  logic [ST_W-1:0] st,
  output logic            verdict_valid,
  output logic [1:0]      verdict,
  output logic            done_valid,
  output logic            done_ok
);
  logic          armed_q;
  logic          grace_q;
  logic [TW-1:0] cnt_q;
  logic          expire_c;
  logic          early_c;
  verdict_e      v_c;

  assign expire_c = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_timeout};
  assign early_c  = st[B_AUXL] & st[B_AUXH];

  always_comb begin
    if (grace_q)                    v_c = V_PIO;
    else if (early_c)               v_c = V_WAIT;
    else if (st[B_ERR])             v_c = V_FAIL;
    else if (st[B_ACT] | st[B_IRQ]) v_c = V_WAIT;
    else                            v_c = V_BUSRST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      grace_q <= 1'b0;
      cnt_q <= '0;
      verdict_valid <= 1'b0;
      verdict <= V_WAIT;
      done_valid <= 1'b0;
      done_ok <= 1'b0;
    end else begin
      verdict_valid <= 1'b0;
      done_valid <= 1'b0;
      if (xfer_start) begin
        armed_q <= 1'b1;
        grace_q <= 1'b0;
        cnt_q <= '0;
      end else if (xfer_end) begin
        armed_q <= 1'b0;
        cnt_q <= '0;
        done_valid <= 1'b1;
        done_ok <= ~st[B_ERR] & drv_ready & ~drv_drq;
      end else if (armed_q && tick) begin
        if (expire_c) begin
          verdict_valid <= 1'b1;
          verdict <= v_c;
          cnt_q <= '0;
          if (v_c != V_WAIT) armed_q <= 1'b0;
          if (!early_c) grace_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R9
  pio_needs_grace_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict == V_PIO) |-> $past(grace_q));
  // R9
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict != V_WAIT) |-> !armed_q);
  // R10
  wait_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict == V_WAIT) |-> (armed_q && cnt_q == '0));
  // R11
  end_beats_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> (!verdict_valid && done_valid));
endmodule

// File: rtl/bmdma_status_wdog.sv
module bmdma_status_wdog
  import bmdma_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eng_active,
  input  logic          eng_err_evt,
  input  logic          eng_irq_evt,
  input  logic [1:0]    eng_aux,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  input  logic          unit_off_req,
  input  logic          unit_off_sel,
  output logic [7:0]    status,
  input  logic          tick,
  input  logic [TW-1:0] cfg_timeout,
  input  logic          xfer_start,
  input  logic          xfer_end,
  input  logic          drv_ready,
  input  logic          drv_drq,
  output logic          verdict_valid,
  output logic [1:0]    verdict,
  output logic          done_valid,
  output logic          done_ok
);
  logic [ST_W-1:0] st_w;

  bmdma_status_reg u_status (
    .clk(clk), .rst(rst),
    .eng_active(eng_active), .eng_err_evt(eng_err_evt), .eng_irq_evt(eng_irq_evt),
    .eng_aux(eng_aux), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .unit_off_req(unit_off_req), .unit_off_sel(unit_off_sel), .st_q(st_w)
  );

  bmdma_watchdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst(rst), .tick(tick), .cfg_timeout(cfg_timeout),
    .xfer_start(xfer_start), .xfer_end(xfer_end),
    .drv_ready(drv_ready), .drv_drq(drv_drq), .st(st_w),
    .verdict_valid(verdict_valid), .verdict(verdict),
    .done_valid(done_valid), .done_ok(done_ok)
  );

  assign status = st_w;
endmodule

// File: tb/bmdma_status_wdog_tb.sv
module bmdma_status_wdog_tb;
  localparam int TW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eng_active = 0, eng_err_evt = 0, eng_irq_evt = 0;
  logic [1:0] eng_aux = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic unit_off_req = 0, unit_off_sel = 0;
  logic [7:0] status;
  logic tick = 0;
  logic [TW-1:0] cfg_timeout = 3;
  logic xfer_start = 0, xfer_end = 0, drv_ready = 0, drv_drq = 0;
  logic verdict_valid, done_valid, done_ok;
  logic [1:0] verdict;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_v[$];
  string exp_tag[$];

  always #4 clk = ~clk;

  bmdma_status_wdog #(.TW(TW)) u_dut (
    .clk(clk), .rst(rst), .eng_active(eng_active), .eng_err_evt(eng_err_evt),
    .eng_irq_evt(eng_irq_evt), .eng_aux(eng_aux), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .unit_off_req(unit_off_req), .unit_off_sel(unit_off_sel), .status(status),
    .tick(tick), .cfg_timeout(cfg_timeout), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .drv_ready(drv_ready), .drv_drq(drv_drq), .verdict_valid(verdict_valid),
    .verdict(verdict), .done_valid(done_valid), .done_ok(done_ok)
  );

  task automatic chk(input logic ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_v(input logic [1:0] v, input string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0;
    end
  endtask

  task automatic start();
    xfer_start = 1; step(); xfer_start = 0;
  endtask

  task automatic finish_xfer(input logic rdy, input logic drq, input logic exp_ok, input string tag);
    drv_ready = rdy; drv_drq = drq; xfer_end = 1; step(); xfer_end = 0;
    chk(done_valid === 1'b1, tag, done_valid, 1);
    chk(done_ok === exp_ok, tag, done_ok, exp_ok);
  endtask

  // Monitor: every issued verdict must match the next queued expectation
  always @(negedge clk) begin
    if (!rst && verdict_valid) begin
      if (exp_v.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected verdict got %0h expected none", verdict);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        chk(verdict === e, t, verdict, e);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout got hang expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(status === 8'h00, "R1 status", status, 0);
    chk(verdict_valid === 1'b0 && done_valid === 1'b0, "R1 pulses", {verdict_valid, done_valid}, 0);
    ticks(4); // R6 unarmed ticks ignored (monitor flags any verdict)

    // R2 mirrors and ignored writes
    eng_active = 1; step();
    chk(status === 8'h01, "R2 active", status, 8'h01);
    eng_active = 0; wr(8'h99);
    chk(status === 8'h00, "R2 writes ignored", status, 8'h00);
    eng_aux = 2'b11; step();
    chk(status === 8'h18, "R2 aux", status, 8'h18);
    eng_aux = 2'b00; step();

    // R3 write-1-clear event bits
    eng_err_evt = 1; step(); eng_err_evt = 0;
    chk(status === 8'h02, "R3 err set", status, 8'h02);
    eng_irq_evt = 1; step(); eng_irq_evt = 0;
    chk(status === 8'h06, "R3 irq set", status, 8'h06);
    wr(8'h02);
    chk(status === 8'h04, "R3 clear err", status, 8'h04);
    wr(8'h00);
    chk(status === 8'h04, "R3 zero write", status, 8'h04);
    eng_irq_evt = 1; wr(8'h04); eng_irq_evt = 0;
    chk(status === 8'h04, "R3 set wins", status, 8'h04);
    wr(8'h04);
    chk(status === 8'h00, "R3 clear irq", status, 8'h00);

    // R4 / R5 drive flags
    wr(8'h60);
    chk(status === 8'h60, "R4 flags", status, 8'h60);
    unit_off_req = 1; unit_off_sel = 1; step(); unit_off_req = 0;
    chk(status === 8'h20, "R5 off unit1", status, 8'h20);
    eng_err_evt = 1; step(); eng_err_evt = 0;
    unit_off_req = 1; unit_off_sel = 0; step(); unit_off_req = 0;
    chk(status === 8'h02, "R5 off unit0 keeps err", status, 8'h02);
    unit_off_req = 1; unit_off_sel = 1; wr(8'h62); unit_off_req = 0;
    chk(status === 8'h20, "R5 off beats write", status, 8'h20);
    wr(8'h00);
    chk(status === 8'h00, "R4 flags cleared", status, 8'h00);

    // R6 R7 R8: early wait keeps grace, then error fails
    cfg_timeout = 3;
    eng_aux = 2'b11; step();
    start();
    ticks(2);
    chk(exp_v.size() == 0, "R6 no early expiry", exp_v.size(), 0);
    expect_v(2'b00, "R7 early wait");
    ticks(1);
    step();
    eng_aux = 2'b00;
    eng_err_evt = 1; step(); eng_err_evt = 0;
    expect_v(2'b01, "R8 error fail");
    ticks(3);
    ticks(5); // R9 disarmed after fail
    wr(8'h02);

    // R8 R9 R10: active wait spends grace, next expiry falls back
    eng_active = 1; step();
    start();
    expect_v(2'b00, "R8 active wait");
    ticks(3);
    expect_v(2'b11, "R9 pio after grace");
    ticks(2);
    chk(exp_v.size() == 1, "R10 full recount", exp_v.size(), 1);
    ticks(1);
    eng_active = 0; step();
    ticks(4);

    // R8 bus reset and R6 zero timeout
    cfg_timeout = 0;
    start();
    expect_v(2'b10, "R8 bus reset / R6 zero");
    ticks(1);

    // R7 repeated early waits never spend grace
    cfg_timeout = 2;
    eng_aux = 2'b11; step();
    start();
    expect_v(2'b00, "R7 early 1"); ticks(2);
    expect_v(2'b00, "R7 early 2"); ticks(2);
    eng_aux = 2'b00; step();
    expect_v(2'b10, "R7 grace unspent -> reset"); ticks(2);

    // R8 irq wait then R11 clean completion
    eng_irq_evt = 1; step(); eng_irq_evt = 0;
    start();
    expect_v(2'b00, "R8 irq wait"); ticks(2);
    wr(8'h04);
    finish_xfer(1, 0, 1, "R11 clean done");
    ticks(4);

    // R11 faulty completions
    start(); finish_xfer(1, 1, 0, "R11 drq pending");
    start(); finish_xfer(0, 0, 0, "R11 not ready");
    eng_err_evt = 1; step(); eng_err_evt = 0;
    start(); finish_xfer(1, 0, 0, "R11 error bit");
    wr(8'h02);

    // R11 end in same cycle as expiry
    cfg_timeout = 1;
    start();
    drv_ready = 1; drv_drq = 0; tick = 1; xfer_end = 1; step(); tick = 0; xfer_end = 0;
    chk(done_valid === 1'b1 && verdict_valid === 1'b0, "R11 end beats expiry",
        {done_valid, verdict_valid}, 2'b10);
    ticks(3);

    step(); step();
    chk(exp_v.size() == 0, "R6 all verdicts seen", exp_v.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule